// File: doc/BRIEF.md
# Nine-Bit Serial Port with Sticky Framing Check

This block is a full-duplex asynchronous serial port with one transmit line and one receive line. Each direction carries either a ten-bit frame (start, eight data bits, stop) or an eleven-bit frame that adds a ninth data bit before the stop bit. A processor can use the ninth bit to mark a frame as a command or as data. Bit timing comes from an external strobe, `os_tick`, that pulses sixteen times per bit period.

On the processor side the block takes a byte write that starts transmission, along with the ninth bit to send. It also has a receive-arm control, sticky done flags that software clears, and a sticky framing-error flag. One status bit position is shared: it reads and writes the framing-error flag while the check is enabled, and the frame-length mode bit while the check is off. Turning on the framing check also delays the receive-done flag from the last data bit to the stop bit.

Top module: `uart9_port`

## Requirements
- R1: `tx_line` is high when the transmitter is idle. A transmitted frame is a low start bit, then eight data bits with the least significant bit first, then (only when the mode bit is 1) the ninth bit taken from `tx_bit9` at the write, then a high stop bit. Every bit lasts exactly 16 `os_tick` pulses.
- R2: A `wr_data` pulse while the transmitter is idle starts a frame, and `tx_line` is low from the clock edge that samples the pulse. A `wr_data` pulse during a frame is ignored.
- R3: `tx_done` goes to 1 at the clock edge that ends the stop bit, which is the edge where the transmitter becomes idle. It stays at 1 until `clr_tx_done`. When a set and a clear happen in the same cycle, the set wins.
- R4: The receiver starts a frame only when `rx_en` is 1 and it sees a high-to-low change on the receive line after a two-stage synchronizer. Each bit is sampled on the 8th tick of its period. If the start bit is high at its sample point, the frame is dropped and the receiver returns to idle with no flag changes.
- R5: With the framing check off, `rx_done` goes to 1 at the sample of the last data bit: the 8th bit in ten-bit mode, the ninth bit in eleven-bit mode. With the check on, it goes to 1 at the stop-bit sample. It stays at 1 until `clr_rx_done`, and a set wins over a clear.
- R6: `rx_byte` holds the eight data bits, with the first received bit in bit 0. It is loaded at the moment `rx_done` is set. `rx_bit9` holds the ninth bit in eleven-bit mode. In ten-bit mode it holds the sampled stop-bit value.
- R7: With `fe_check_en` = 1, a stop bit sampled low sets the framing-error flag. Later frames with a good stop bit leave the flag set. Only a status write with the check enabled, or reset, changes it.
- R8: `stat_bit` reads the framing-error flag when `fe_check_en` = 1 and the mode bit when it is 0. `stat_wr` writes `stat_wdata` into that same selected flag. Mode 1 selects eleven-bit frames and mode 0 selects ten-bit frames.
- R9: After reset, `tx_line` = 1, both done flags = 0, the error flag = 0, the mode = 0, and `rx_byte` = 0 and `rx_bit9` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit |
| rx_line | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |
| wr_data | input | 1 | Byte write strobe, starts a frame |
| wr_byte | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in eleven-bit mode |
| rx_en | input | 1 | Arms the receiver |
| fe_check_en | input | 1 | Enables the stop-bit check and selects the shared status bit |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| stat_wr | input | 1 | Writes the shared status bit |
| stat_wdata | input | 1 | Value for the shared status bit |
| stat_bit | output | 1 | Error flag or mode bit, selected by `fe_check_en` |
| rx_byte | output | 8 | Last received byte |
| rx_bit9 | output | 1 | Received ninth bit, or the stop bit in ten-bit mode |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |

## Verification
If the tick phase or bit index inside either engine is wrong, `tx_line` shifts by at least one clock at a bit boundary. On the receive side, `rx_done` rises on the wrong edge. A reference that follows the same tick count every clock catches either fault within one bit period of where it occurs. A mode or error flag in the wrong state shows at once on `stat_bit`, and it changes the frame length of the next transmission. A lost sticky error shows on the first good frame after a bad stop bit.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    // Receive engine state.
    typedef enum logic [0:0] {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              b9_i,
    input  logic              nine_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int PH_W  = $clog2(OSR);
    localparam int FR_W  = DATA_W + 3;
    localparam int CNT_W = $clog2(FR_W + 1);

    typedef struct packed {
        logic             busy;
        logic [PH_W-1:0]  ph;
        logic [FR_W-1:0]  sh;
        logic [CNT_W-1:0] left;
        logic             line;
    } tx_reg_t;

    tx_reg_t q, d;
    logic    fin;

    always_comb begin
        d   = q;
        fin = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.ph   = '0;
                if (nine_i) begin
                    d.sh   = {1'b1, b9_i, data_i, 1'b0};
                    d.left = CNT_W'(FR_W);
                end else begin
                    d.sh   = {2'b11, data_i, 1'b0};
                    d.left = CNT_W'(FR_W - 1);
                end
            end
        end else if (tick_i) begin
            if (q.ph == PH_W'(OSR - 1)) begin
                d.ph   = '0;
                d.sh   = {1'b1, q.sh[FR_W-1:1]};
                d.left = q.left - CNT_W'(1);
                if (q.left == CNT_W'(1)) begin
                    d.busy = 1'b0;
                    fin    = 1'b1;
                end
            end else begin
                d.ph = q.ph + PH_W'(1);
            end
        end
        d.line = d.busy ? d.sh[0] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.busy <= 1'b0;
            q.ph   <= '0;
            q.sh   <= '1;
            q.left <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.line;
    assign busy_o = q.busy;
    assign done_o = fin;

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              en_i,
    input  logic              nine_i,
    input  logic              chk_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              b9_o,
    output logic              done_o,
    output logic              ferr_o
);
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 3);
    localparam int MID   = OSR / 2 - 1;

    typedef struct packed {
        rx_state_e         st;
        logic [PH_W-1:0]   ph;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              b9t;
        logic [DATA_W-1:0] rbyte;
        logic              rb9;
        logic [SYNC-1:0]   sync;
        logic              prev;
    } rx_reg_t;

    rx_reg_t          q, d;
    logic             rxs;
    logic             fall;
    logic             got;
    logic             bad;
    logic [IDX_W-1:0] stop_idx;

    assign rxs      = q.sync[SYNC-1];
    assign fall     = q.prev & ~rxs;
    assign stop_idx = nine_i ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);

    always_comb begin
        d      = q;
        got    = 1'b0;
        bad    = 1'b0;
        d.sync = {q.sync[SYNC-2:0], line_i};
        d.prev = rxs;
        unique case (q.st)
            RX_IDLE: begin
                if (en_i && fall) begin
                    d.st  = RX_BUSY;
                    d.ph  = '0;
                    d.idx = '0;
                end
            end
            RX_BUSY: begin
                if (tick_i) begin
                    if (q.ph == PH_W'(MID)) begin
                        if (q.idx == '0) begin
                            if (rxs) begin
                                d.st = RX_IDLE;
                            end
                        end else if (q.idx <= IDX_W'(DATA_W)) begin
                            d.sh = {rxs, q.sh[DATA_W-1:1]};
                            if (q.idx == IDX_W'(DATA_W) && !nine_i && !chk_i) begin
                                got     = 1'b1;
                                d.rbyte = d.sh;
                            end
                        end else if (q.idx == stop_idx) begin
                            d.st = RX_IDLE;
                            if (chk_i) begin
                                got     = 1'b1;
                                bad     = ~rxs;
                                d.rbyte = q.sh;
                                d.rb9   = nine_i ? q.b9t : rxs;
                            end else if (!nine_i) begin
                                d.rb9 = rxs;
                            end
                        end else begin
                            d.b9t = rxs;
                            if (!chk_i) begin
                                got     = 1'b1;
                                d.rbyte = q.sh;
                                d.rb9   = rxs;
                            end
                        end
                    end
                    if (q.ph == PH_W'(OSR - 1)) begin
                        d.ph  = '0;
                        d.idx = q.idx + IDX_W'(1);
                    end else begin
                        d.ph = q.ph + PH_W'(1);
                    end
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= RX_IDLE;
            q.ph    <= '0;
            q.idx   <= '0;
            q.sh    <= '0;
            q.b9t   <= 1'b0;
            q.rbyte <= '0;
            q.rb9   <= 1'b0;
            q.sync  <= '1;
            q.prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign byte_o = q.rbyte;
    assign b9_o   = q.rb9;
    assign done_o = got;
    assign ferr_o = bad;

endmodule

// File: rtl/uart9_port.sv
module uart9_port #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    output logic              tx_line,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              tx_bit9,
    input  logic              rx_en,
    input  logic              fe_check_en,
    input  logic              clr_tx_done,
    input  logic              clr_rx_done,
    input  logic              stat_wr,
    input  logic              stat_wdata,
    output logic              stat_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              tx_done,
    output logic              rx_done
);
    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic fe;
        logic mode9;
    } flag_reg_t;

    flag_reg_t q, d;
    logic      tx_busy;
    logic      tx_fin;
    logic      rx_fin;
    logic      fe_hit;
    logic      fe_flag;
    logic      mode9;

    assign fe_flag = q.fe;
    assign mode9   = q.mode9;

    uart9_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (os_tick),
        .start_i (wr_data),
        .data_i  (wr_byte),
        .b9_i    (tx_bit9),
        .nine_i  (mode9),
        .line_o  (tx_line),
        .busy_o  (tx_busy),
        .done_o  (tx_fin)
    );

    uart9_rx #(.DATA_W(DATA_W), .OSR(OSR), .SYNC(SYNC)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (os_tick),
        .line_i  (rx_line),
        .en_i    (rx_en),
        .nine_i  (mode9),
        .chk_i   (fe_check_en),
        .byte_o  (rx_byte),
        .b9_o    (rx_bit9),
        .done_o  (rx_fin),
        .ferr_o  (fe_hit)
    );

    always_comb begin
        d = q;
        if (clr_tx_done) d.tx_done = 1'b0;
        if (tx_fin)      d.tx_done = 1'b1;
        if (clr_rx_done) d.rx_done = 1'b0;
        if (rx_fin)      d.rx_done = 1'b1;
        if (stat_wr) begin
            if (fe_check_en) d.fe    = stat_wdata;
            else             d.mode9 = stat_wdata;
        end
        if (fe_hit) d.fe = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stat_bit = fe_check_en ? q.fe : q.mode9;
    assign tx_done  = q.tx_done;
    assign rx_done  = q.rx_done;

endmodule

// File: rtl/uart9_sva.sv
module uart9_sva (
    input logic clk,
    input logic rst_n,
    input logic tx_line,
    input logic tx_busy,
    input logic tx_done,
    input logic rx_done,
    input logic rx_fin,
    input logic clr_rx_done,
    input logic fe_flag,
    input logic fe_hit,
    input logic stat_wr,
    input logic fe_check_en
);
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);

    a_r3_done_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> tx_done);

    a_r5_rx_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !clr_rx_done |=> rx_done);

    a_r5_rx_done_raised: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fin |=> rx_done);

    a_r7_fe_held: assert property (@(posedge clk) disable iff (!rst_n)
        fe_flag && !(stat_wr && fe_check_en) |=> fe_flag);

    a_r7_fe_on_bad_stop: assert property (@(posedge clk) disable iff (!rst_n)
        fe_hit |=> fe_flag);
endmodule

bind uart9_port uart9_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_line     (tx_line),
    .tx_busy     (tx_busy),
    .tx_done     (tx_done),
    .rx_done     (rx_done),
    .rx_fin      (rx_fin),
    .clr_rx_done (clr_rx_done),
    .fe_flag     (fe_flag),
    .fe_hit      (fe_hit),
    .stat_wr     (stat_wr),
    .fe_check_en (fe_check_en)
);

// File: tb/uart9_port_test.sv
module uart9_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       tx_line;
    logic       wr_data = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       tx_bit9 = 1'b0;
    logic       rx_en = 1'b0;
    logic       fe_check_en = 1'b0;
    logic       clr_tx_done = 1'b0;
    logic       clr_rx_done = 1'b0;
    logic       stat_wr = 1'b0;
    logic       stat_wdata = 1'b0;
    logic       stat_bit;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       tx_done;
    logic       rx_done;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int tcnt   = 0;

    uart9_port uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .tx_line(tx_line), .wr_data(wr_data), .wr_byte(wr_byte),
        .tx_bit9(tx_bit9), .rx_en(rx_en), .fe_check_en(fe_check_en),
        .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_bit(stat_bit),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .tx_done(tx_done),
        .rx_done(rx_done)
    );

    always #4 clk = ~clk;

    // 16x tick: one pulse every 4 clocks, so one bit = 64 clocks.
    always @(negedge clk) begin
        tcnt    = (tcnt + 1) % 4;
        os_tick = (tcnt == 0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_txq[$];
    int       m_tph;
    bit       m_txline;
    bit       m_rxact;
    int       m_ph, m_idx;
    bit [7:0] m_sh, m_byte;
    bit       m_b9t, m_b9;
    bit       m_txdone, m_rxdone, m_fe, m_mode;
    bit       m_s1, m_s2, m_prev;
    bit       rxs, tx_ev, rx_ev, fe_ev;
    int       stop_i;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txq.delete(); m_tph = 0; m_txline = 1;
            m_rxact = 0; m_ph = 0; m_idx = 0; m_sh = 0; m_byte = 0;
            m_b9t = 0; m_b9 = 0; m_txdone = 0; m_rxdone = 0; m_fe = 0; m_mode = 0;
            m_s1 = 1; m_s2 = 1; m_prev = 1;
        end else begin
            rxs = m_s2; tx_ev = 0; rx_ev = 0; fe_ev = 0;
            if (m_txq.size() == 0) begin
                if (wr_data) begin
                    m_txq.push_back(1'b0);
                    for (int i = 0; i < 8; i++) m_txq.push_back(wr_byte[i]);
                    if (m_mode) m_txq.push_back(tx_bit9);
                    m_txq.push_back(1'b1);
                    m_tph = 0;
                end
            end else if (os_tick) begin
                if (m_tph == 15) begin
                    m_tph = 0;
                    void'(m_txq.pop_front());
                    if (m_txq.size() == 0) tx_ev = 1;
                end else m_tph++;
            end
            m_txline = (m_txq.size() == 0) ? 1'b1 : m_txq[0];

            stop_i = m_mode ? 10 : 9;
            if (!m_rxact) begin
                if (rx_en && m_prev && !rxs) begin
                    m_rxact = 1; m_ph = 0; m_idx = 0;
                end
            end else if (os_tick) begin
                if (m_ph == 7) begin
                    if (m_idx == 0) begin
                        if (rxs) m_rxact = 0;
                    end else if (m_idx <= 8) begin
                        m_sh = {rxs, m_sh[7:1]};
                        if (m_idx == 8 && !m_mode && !fe_check_en) begin
                            rx_ev = 1; m_byte = m_sh;
                        end
                    end else if (m_idx == stop_i) begin
                        m_rxact = 0;
                        if (fe_check_en) begin
                            rx_ev = 1; m_byte = m_sh;
                            m_b9 = m_mode ? m_b9t : rxs;
                            if (!rxs) fe_ev = 1;
                        end else if (!m_mode) m_b9 = rxs;
                    end else begin
                        m_b9t = rxs;
                        if (!fe_check_en) begin
                            rx_ev = 1; m_byte = m_sh; m_b9 = rxs;
                        end
                    end
                end
                if (m_ph == 15) begin m_ph = 0; m_idx++; end else m_ph++;
            end

            if (clr_tx_done) m_txdone = 0;
            if (tx_ev) m_txdone = 1;
            if (clr_rx_done) m_rxdone = 0;
            if (rx_ev) m_rxdone = 1;
            if (stat_wr) begin
                if (fe_check_en) m_fe = stat_wdata; else m_mode = stat_wdata;
            end
            if (fe_ev) m_fe = 1;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_line;
        end
    end

    // Compare every clock, away from both edges.
    always @(posedge clk) begin
        #3;
        cycles++;
        if (rst_n) begin
            check(tx_line === m_txline, "R1 tx_line", tx_line, m_txline);
            check(tx_done === m_txdone, "R3 tx_done", tx_done, m_txdone);
            check(rx_done === m_rxdone, "R5 rx_done", rx_done, m_rxdone);
            check(rx_byte === m_byte, "R6 rx_byte", rx_byte, m_byte);
            check(rx_bit9 === m_b9, "R6 rx_bit9", rx_bit9, m_b9);
            check(stat_bit === (fe_check_en ? m_fe : m_mode), "R8 stat_bit",
                  stat_bit, fe_check_en ? m_fe : m_mode);
        end
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_tx(input logic [7:0] b, input logic b9);
        @(negedge clk);
        wr_byte = b; tx_bit9 = b9; wr_data = 1'b1;
        @(negedge clk);
        wr_data = 1'b0;
    endtask

    task automatic wait_tx_done();
        for (int i = 0; i < 1000 && !tx_done; i++) @(negedge clk);
    endtask

    task automatic pulse_clr(input bit txc, input bit rxc);
        @(negedge clk);
        clr_tx_done = txc; clr_rx_done = rxc;
        @(negedge clk);
        clr_tx_done = 1'b0; clr_rx_done = 1'b0;
    endtask

    task automatic write_stat(input bit v);
        @(negedge clk);
        stat_wr = 1'b1; stat_wdata = v;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic b9, input logic stopv, input bit nine);
        @(negedge clk);
        rx_line = 1'b0; idle(64);
        for (int i = 0; i < 8; i++) begin rx_line = b[i]; idle(64); end
        if (nine) begin rx_line = b9; idle(64); end
        rx_line = stopv; idle(64);
        rx_line = 1'b1; idle(48);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);
        // R9: reset state
        check(tx_line === 1'b1, "R9 tx_line", tx_line, 1);
        check(tx_done === 1'b0 && rx_done === 1'b0, "R9 flags", {tx_done, rx_done}, 0);
        check(stat_bit === 1'b0, "R9 stat_bit", stat_bit, 0);
        check(rx_byte === 8'h00 && rx_bit9 === 1'b0, "R9 rx_byte", rx_byte, 0);

        // R1/R2: ten-bit transmit, extra write during frame ignored
        @(negedge clk);
        wr_byte = 8'hA5; wr_data = 1'b1;
        @(negedge clk);
        wr_data = 1'b0;
        check(tx_line === 1'b0, "R2 start low", tx_line, 0);
        idle(200);
        send_tx(8'hFF, 1'b1);
        wait_tx_done();
        check(tx_done === 1'b1, "R3 tx_done set", tx_done, 1);
        idle(100);
        check(tx_line === 1'b1, "R2 busy write ignored", tx_line, 1);
        pulse_clr(1'b1, 1'b0);
        check(tx_done === 1'b0, "R3 tx_done cleared", tx_done, 0);

        // R8: mode bit through the shared position, then eleven-bit transmit
        write_stat(1'b1);
        check(stat_bit === 1'b1, "R8 mode readback", stat_bit, 1);
        send_tx(8'h3C, 1'b1);
        wait_tx_done();
        check(tx_done === 1'b1, "R1 eleven-bit frame done", tx_done, 1);
        pulse_clr(1'b1, 1'b0);

        // R5/R6: eleven-bit receive, check off
        rx_en = 1'b1;
        send_rx(8'h5A, 1'b0, 1'b1, 1'b1);
        check(rx_done === 1'b1, "R5 rx_done", rx_done, 1);
        check(rx_byte === 8'h5A, "R6 byte", rx_byte, 8'h5A);
        check(rx_bit9 === 1'b0, "R6 ninth bit", rx_bit9, 0);
        pulse_clr(1'b0, 1'b1);

        // R7: check on, good frame then bad stop, then sticky
        fe_check_en = 1'b1;
        send_rx(8'hC3, 1'b1, 1'b1, 1'b1);
        check(stat_bit === 1'b0, "R7 no error on good stop", stat_bit, 0);
        check(rx_bit9 === 1'b1 && rx_byte === 8'hC3, "R6 ninth bit checked", {rx_bit9, rx_byte}, 9'h1C3);
        pulse_clr(1'b0, 1'b1);
        send_rx(8'h0F, 1'b0, 1'b0, 1'b1);
        check(stat_bit === 1'b1, "R7 error set", stat_bit, 1);
        send_rx(8'hF0, 1'b0, 1'b1, 1'b1);
        check(stat_bit === 1'b1, "R7 error sticky", stat_bit, 1);
        write_stat(1'b0);
        check(stat_bit === 1'b0, "R7 error cleared", stat_bit, 0);
        fe_check_en = 1'b0;
        idle(1);
        check(stat_bit === 1'b1, "R8 mode kept", stat_bit, 1);

        // R6: ten-bit receive stores stop bit as ninth bit
        write_stat(1'b0);
        pulse_clr(1'b0, 1'b1);
        send_rx(8'h81, 1'b0, 1'b1, 1'b0);
        check(rx_byte === 8'h81 && rx_bit9 === 1'b1, "R6 stop in ninth", {rx_bit9, rx_byte}, 9'h181);
        fe_check_en = 1'b1;
        send_rx(8'h42, 1'b0, 1'b0, 1'b0);
        check(rx_bit9 === 1'b0 && stat_bit === 1'b1, "R7 ten-bit bad stop", {rx_bit9, stat_bit}, 1);
        write_stat(1'b0);
        fe_check_en = 1'b0;

        // R4: disarmed receiver ignores a frame
        pulse_clr(1'b0, 1'b1);
        rx_en = 1'b0;
        send_rx(8'h11, 1'b0, 1'b1, 1'b0);
        check(rx_done === 1'b0 && rx_byte === 8'h42, "R4 disarmed", {rx_done, rx_byte}, 8'h42);

        // R4: short start glitch rejected
        rx_en = 1'b1;
        @(negedge clk);
        rx_line = 1'b0; idle(12);
        rx_line = 1'b1; idle(200);
        check(rx_done === 1'b0, "R4 glitch ignored", rx_done, 0);
        send_rx(8'h77, 1'b0, 1'b1, 1'b0);
        check(rx_done === 1'b1 && rx_byte === 8'h77, "R4 frame after glitch", {rx_done, rx_byte}, 9'h177);
        pulse_clr(1'b0, 1'b1);

        // Full duplex: both directions at once
        fork
            send_rx(8'h96, 1'b0, 1'b1, 1'b0);
            begin idle(30); send_tx(8'h69, 1'b0); end
        join
        wait_tx_done();
        check(rx_byte === 8'h96, "R6 duplex receive", rx_byte, 8'h96);
        check(tx_done === 1'b1, "R3 duplex transmit", tx_done, 1);

        idle(20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule